// File: doc/BRIEF.md
# Flash Page Program-Verify Sequencer

This block programs one page of an on-chip flash array and confirms the result, with no processor involvement during the operation. Before the run, the host fills the block's target buffer through a byte-wide load port. After a single-cycle `start`, the block raises the array's write-enable and streams the page into the array's write latches. It then applies a timed program pulse and reads every byte back in verify mode. For each byte that has not yet reached its target, the block rebuilds the data to apply next from the verify result. It repeats this until the page verifies or the attempt limit is reached.

The pulse width depends on the attempt. Attempts up to a configurable early limit use a short pulse, and later attempts use a longer one. When the page verifies within the early limit, the block writes a reinforcement pattern and applies one further pulse with its own width, without verifying again. Every settling delay is a parameter in clock cycles, and one shared down-counter times all of them. A watchdog-enable output is high for the whole of each pulse subroutine. The run ends with a one-cycle `done` or `fail` pulse. The attempt count stays visible on `attempts` until the next start.

Top module: `flash_pgm_seq`

## Requirements
- R1: In the cycle after `start` is sampled high while idle, `busy` and `fl_swe` go high. They are held for T_SWE_ON cycles before the first array write.
- R2: Each pulse subroutine is made of four contiguous intervals, each with `wdt_en` high:
  - T_SETUP cycles with `fl_psu` high;
  - the pulse width with `fl_psu` and `fl_prog` high;
  - T_HOLD_A cycles with only `fl_psu` high;
  - T_HOLD_B cycles with neither high.
  
  `fl_prog` is never high without `fl_psu`.
- R3: The pulse width is T_Z1 cycles on attempts 1 to EARLY_TRIES and T_Z2 cycles on later attempts. The reinforcement pulse is T_Z3 cycles.
- R4: Each write phase issues PAGE_BYTES single-cycle writes (`fl_we` high, `fl_pv` low) at addresses 0 upward, one per cycle. On attempt 1 the data is the target byte. On later attempts each byte is (target OR NOT verify-read) from the previous verify, so a bit is programmed again only where the target is 0 and the read was 1.
- R5: Verify raises `fl_pv` for T_PV_ON cycles, then repeats the following for each address from 0 upward:
  - one dummy write of 0xFF;
  - T_SETTLE cycles;
  - one read cycle (`fl_re`), in which `fl_rdata` is sampled.
  
  After the last byte, `fl_pv` is low for T_PV_OFF cycles before the next step. `fl_pv` is never high together with `fl_psu`.
- R6: If any byte differs from its target, the attempt count increments and a new write phase starts. If the count already equals MAX_TRIES, the run ends in failure instead.
- R7: If every byte verifies on an attempt no greater than EARLY_TRIES, the block writes a reinforcement page of bytes (target OR verify-read) and applies one T_Z3 pulse. It then ends in success without another verify.
- R8: If every byte verifies on an attempt greater than EARLY_TRIES, the run ends in success with no reinforcement phase.
- R9: At the end of every run, `fl_swe` is low for T_EXIT cycles while `busy` stays high. The next cycle is idle and carries exactly one cycle of `done` (success) or `fail` (failure).
- R10: `start` has no effect while `busy` is high.
- R11: After reset, all outputs are low and `attempts` is 0. After a run, `attempts` holds the final attempt number.
- R12: While idle, `ld_we` writes `ld_data` into the target buffer at `ld_addr`. This is the page that the next run programs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (sampled while idle) |
| ld_we | input | 1 | Target buffer write strobe |
| ld_addr | input | clog2(PAGE_BYTES) | Target buffer byte address |
| ld_data | input | 8 | Target buffer byte |
| fl_swe | output | 1 | Array software write enable |
| fl_psu | output | 1 | Array program setup |
| fl_prog | output | 1 | Array program pulse |
| fl_pv | output | 1 | Array program-verify mode |
| wdt_en | output | 1 | Watchdog enable during pulse subroutine |
| fl_we | output | 1 | Array byte write strobe |
| fl_re | output | 1 | Array verify read strobe |
| fl_addr | output | clog2(PAGE_BYTES) | Array byte address (0 when no access) |
| fl_wdata | output | 8 | Array write data (0 when no write) |
| fl_rdata | input | 8 | Array read data, valid in the `fl_re` cycle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle success pulse |
| fail | output | 1 | One-cycle failure pulse |
| attempts | output | clog2(MAX_TRIES+1) | Current or final attempt number |

## Verification
The properties assume the following about the inputs:
- every timing parameter is at least one cycle;
- EARLY_TRIES is below MAX_TRIES;
- the array returns verify data combinationally in the read cycle.

The stimulus keeps within these limits. The bench uses short non-zero delays and a behavioural array model that answers in the same cycle. The model programs a byte only after a per-byte number of pulses, and it can hold individual bits stuck at zero. This produces early passes, passes after the pulse width has changed, and exhaustion of the attempt limit. The bench also pulses `start` in the middle of a run, and it loads the page only while the block is idle.

// File: rtl/fps_pkg.sv
package fps_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SWE,
        ST_WR,
        ST_PSU,
        ST_PULSE,
        ST_HOLD_A,
        ST_HOLD_B,
        ST_PV_ON,
        ST_DUMMY,
        ST_SETTLE,
        ST_RD,
        ST_PV_OFF,
        ST_EXIT
    } fps_state_e;

    localparam logic [7:0] BYTE_ERASED = 8'hFF;

    function automatic int fps_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fps_wait_timer.sv
module fps_wait_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R2: a loaded wait always runs down one step per cycle
    assert_timer_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/fps_byte_store.sv
module fps_byte_store #(
    parameter int DEPTH = 128,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/fps_verify_calc.sv
module fps_verify_calc (
    input  logic [7:0] target,
    input  logic [7:0] readback,
    output logic       match,
    output logic [7:0] retry_byte,
    output logic [7:0] reinforce_byte
);
    always_comb begin
        match          = (readback == target);
        // zero survives only where the target wants 0 and the cell still reads 1
        retry_byte     = target | ~readback;
        // zero only where the target wants 0 and the cell already reads 0
        reinforce_byte = target | readback;
    end
endmodule

// File: rtl/flash_pgm_seq.sv
module flash_pgm_seq
    import fps_pkg::*;
#(
    parameter int PAGE_BYTES  = 128,
    parameter int EARLY_TRIES = 6,
    parameter int MAX_TRIES   = 1000,
    parameter int T_SWE_ON    = 200,
    parameter int T_SETUP     = 100,
    parameter int T_Z1        = 600,
    parameter int T_Z2        = 4000,
    parameter int T_Z3        = 400,
    parameter int T_HOLD_A    = 100,
    parameter int T_HOLD_B    = 200,
    parameter int T_PV_ON     = 80,
    parameter int T_SETTLE    = 40,
    parameter int T_PV_OFF    = 40,
    parameter int T_EXIT      = 200
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               start,
    input  logic                               ld_we,
    input  logic [$clog2(PAGE_BYTES)-1:0]      ld_addr,
    input  logic [7:0]                         ld_data,
    output logic                               fl_swe,
    output logic                               fl_psu,
    output logic                               fl_prog,
    output logic                               fl_pv,
    output logic                               wdt_en,
    output logic                               fl_we,
    output logic                               fl_re,
    output logic [$clog2(PAGE_BYTES)-1:0]      fl_addr,
    output logic [7:0]                         fl_wdata,
    input  logic [7:0]                         fl_rdata,
    output logic                               busy,
    output logic                               done,
    output logic                               fail,
    output logic [$clog2(MAX_TRIES+1)-1:0]     attempts
);
    localparam int AW   = $clog2(PAGE_BYTES);
    localparam int NW   = $clog2(MAX_TRIES + 1);
    localparam int TMAX = fps_max(fps_max(fps_max(T_SWE_ON, T_SETUP), fps_max(T_Z1, T_Z2)),
                          fps_max(fps_max(fps_max(T_Z3, T_HOLD_A), fps_max(T_HOLD_B, T_PV_ON)),
                          fps_max(fps_max(T_SETTLE, T_PV_OFF), T_EXIT)));
    localparam int CW   = $clog2(TMAX) + 1;
    localparam logic [AW-1:0] LAST_ADDR = AW'(PAGE_BYTES - 1);

    localparam logic [CW-1:0] D_ONE    = '0;
    localparam logic [CW-1:0] D_SWE    = CW'(T_SWE_ON - 1);
    localparam logic [CW-1:0] D_SETUP  = CW'(T_SETUP - 1);
    localparam logic [CW-1:0] D_Z1     = CW'(T_Z1 - 1);
    localparam logic [CW-1:0] D_Z2     = CW'(T_Z2 - 1);
    localparam logic [CW-1:0] D_Z3     = CW'(T_Z3 - 1);
    localparam logic [CW-1:0] D_HOLD_A = CW'(T_HOLD_A - 1);
    localparam logic [CW-1:0] D_HOLD_B = CW'(T_HOLD_B - 1);
    localparam logic [CW-1:0] D_PV_ON  = CW'(T_PV_ON - 1);
    localparam logic [CW-1:0] D_SETTLE = CW'(T_SETTLE - 1);
    localparam logic [CW-1:0] D_PV_OFF = CW'(T_PV_OFF - 1);
    localparam logic [CW-1:0] D_EXIT   = CW'(T_EXIT - 1);

    typedef struct packed {
        fps_state_e      st;
        logic [AW-1:0]   addr;
        logic [NW-1:0]   n;
        logic            xtra;
        logic            bad;
        logic            ok;
        logic            done;
        logic            fail;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_zero;

    logic [7:0] tgt_byte, rep_byte, add_byte;
    logic       vmatch;
    logic [7:0] vrep, vadd;
    logic       early;
    logic       rep_we, add_we, tgt_we;
    logic [7:0] wr_byte;

    fps_wait_timer #(.CW(CW)) timer_i (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_zero)
    );

    assign tgt_we = ld_we && (ctl_q.st == ST_IDLE);
    assign rep_we = (ctl_q.st == ST_RD);
    assign add_we = (ctl_q.st == ST_RD) && vmatch && early;

    fps_byte_store #(.DEPTH(PAGE_BYTES), .AW(AW)) tgt_store_i (
        .clk(clk), .we(tgt_we), .waddr(ld_addr), .wdata(ld_data),
        .raddr(ctl_q.addr), .rdata(tgt_byte)
    );

    fps_byte_store #(.DEPTH(PAGE_BYTES), .AW(AW)) rep_store_i (
        .clk(clk), .we(rep_we), .waddr(ctl_q.addr), .wdata(vrep),
        .raddr(ctl_q.addr), .rdata(rep_byte)
    );

    fps_byte_store #(.DEPTH(PAGE_BYTES), .AW(AW)) add_store_i (
        .clk(clk), .we(add_we), .waddr(ctl_q.addr), .wdata(vadd),
        .raddr(ctl_q.addr), .rdata(add_byte)
    );

    fps_verify_calc vcalc_i (
        .target(tgt_byte), .readback(fl_rdata),
        .match(vmatch), .retry_byte(vrep), .reinforce_byte(vadd)
    );

    assign early = (int'(ctl_q.n) <= EARLY_TRIES);

    // first attempt streams the target itself, later ones the retry data
    always_comb begin
        if (ctl_q.xtra)
            wr_byte = add_byte;
        else if (ctl_q.n == NW'(1))
            wr_byte = tgt_byte;
        else
            wr_byte = rep_byte;
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.fail = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = D_ONE;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.st   = ST_SWE;
                    ctl_d.n    = NW'(1);
                    ctl_d.xtra = 1'b0;
                    ctl_d.bad  = 1'b0;
                    ctl_d.addr = '0;
                    tmr_load   = 1'b1;
                    tmr_val    = D_SWE;
                end
            end
            ST_SWE: begin
                if (tmr_zero) begin
                    ctl_d.st   = ST_WR;
                    ctl_d.addr = '0;
                    tmr_load   = 1'b1;
                end
            end
            ST_WR: begin
                tmr_load = 1'b1;
                if (ctl_q.addr == LAST_ADDR) begin
                    ctl_d.st   = ST_PSU;
                    ctl_d.addr = '0;
                    tmr_val    = D_SETUP;
                end else begin
                    ctl_d.addr = ctl_q.addr + 1'b1;
                end
            end
            ST_PSU: begin
                if (tmr_zero) begin
                    ctl_d.st = ST_PULSE;
                    tmr_load = 1'b1;
                    if (ctl_q.xtra)  tmr_val = D_Z3;
                    else if (early)  tmr_val = D_Z1;
                    else             tmr_val = D_Z2;
                end
            end
            ST_PULSE: begin
                if (tmr_zero) begin
                    ctl_d.st = ST_HOLD_A;
                    tmr_load = 1'b1;
                    tmr_val  = D_HOLD_A;
                end
            end
            ST_HOLD_A: begin
                if (tmr_zero) begin
                    ctl_d.st = ST_HOLD_B;
                    tmr_load = 1'b1;
                    tmr_val  = D_HOLD_B;
                end
            end
            ST_HOLD_B: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    if (ctl_q.xtra) begin
                        ctl_d.st = ST_EXIT;
                        ctl_d.ok = 1'b1;
                        tmr_val  = D_EXIT;
                    end else begin
                        ctl_d.st   = ST_PV_ON;
                        ctl_d.bad  = 1'b0;
                        ctl_d.addr = '0;
                        tmr_val    = D_PV_ON;
                    end
                end
            end
            ST_PV_ON: begin
                if (tmr_zero) begin
                    ctl_d.st = ST_DUMMY;
                    tmr_load = 1'b1;
                end
            end
            ST_DUMMY: begin
                ctl_d.st = ST_SETTLE;
                tmr_load = 1'b1;
                tmr_val  = D_SETTLE;
            end
            ST_SETTLE: begin
                if (tmr_zero) begin
                    ctl_d.st = ST_RD;
                    tmr_load = 1'b1;
                end
            end
            ST_RD: begin
                tmr_load = 1'b1;
                if (!vmatch) ctl_d.bad = 1'b1;
                if (ctl_q.addr == LAST_ADDR) begin
                    ctl_d.st = ST_PV_OFF;
                    tmr_val  = D_PV_OFF;
                end else begin
                    ctl_d.st   = ST_DUMMY;
                    ctl_d.addr = ctl_q.addr + 1'b1;
                end
            end
            ST_PV_OFF: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    if (ctl_q.bad) begin
                        if (int'(ctl_q.n) >= MAX_TRIES) begin
                            ctl_d.st = ST_EXIT;
                            ctl_d.ok = 1'b0;
                            tmr_val  = D_EXIT;
                        end else begin
                            ctl_d.st   = ST_WR;
                            ctl_d.n    = ctl_q.n + 1'b1;
                            ctl_d.addr = '0;
                        end
                    end else if (early) begin
                        ctl_d.st   = ST_WR;
                        ctl_d.xtra = 1'b1;
                        ctl_d.addr = '0;
                    end else begin
                        ctl_d.st = ST_EXIT;
                        ctl_d.ok = 1'b1;
                        tmr_val  = D_EXIT;
                    end
                end
            end
            ST_EXIT: begin
                if (tmr_zero) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.done = ctl_q.ok;
                    ctl_d.fail = !ctl_q.ok;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, addr: '0, n: '0, xtra: 1'b0, bad: 1'b0,
                       ok: 1'b0, done: 1'b0, fail: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // output decode
    always_comb begin
        busy     = (ctl_q.st != ST_IDLE);
        fl_swe   = busy && (ctl_q.st != ST_EXIT);
        fl_psu   = (ctl_q.st == ST_PSU) || (ctl_q.st == ST_PULSE) || (ctl_q.st == ST_HOLD_A);
        fl_prog  = (ctl_q.st == ST_PULSE);
        wdt_en   = fl_psu || (ctl_q.st == ST_HOLD_B);
        fl_pv    = (ctl_q.st == ST_PV_ON) || (ctl_q.st == ST_DUMMY) ||
                   (ctl_q.st == ST_SETTLE) || (ctl_q.st == ST_RD);
        fl_we    = (ctl_q.st == ST_WR) || (ctl_q.st == ST_DUMMY);
        fl_re    = (ctl_q.st == ST_RD);
        fl_addr  = (fl_we || fl_re) ? ctl_q.addr : '0;
        fl_wdata = (ctl_q.st == ST_WR)    ? wr_byte :
                   (ctl_q.st == ST_DUMMY) ? BYTE_ERASED : 8'h00;
        done     = ctl_q.done;
        fail     = ctl_q.fail;
        attempts = ctl_q.n;
    end

    // R2: program pulse only inside setup and watchdog window
    assert_prog_inside_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fl_prog |-> (fl_psu && wdt_en));

    // R2: setup already asserted the cycle before the pulse starts
    assert_setup_before_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_prog) |-> $past(fl_psu));

    // R5: verify mode never overlaps programming controls
    assert_verify_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_pv && (fl_psu || fl_prog)));

    // R9: outcomes exclusive and single-cycle
    assert_single_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fail) |=> !(done || fail));
    assert_outcome_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    // R6: attempt counter bounded by the limit
    assert_try_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(attempts) <= MAX_TRIES);

    // R10: a start during a run never restarts the sequence
    assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && ctl_q.st != ST_SWE) |=> (ctl_q.st != ST_SWE));

endmodule

// File: tb/flash_pgm_seq_tb_top.sv
`timescale 1ns/1ps
module flash_pgm_seq_tb_top;
    localparam int P = 128, EARLY = 6, NMAX = 10;
    localparam int TX = 3, TY = 2, TZ1 = 2, TZ2 = 4, TZ3 = 3, TA = 2, TB = 2;
    localparam int TG = 2, TE = 1, TH = 2, TT = 3;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic ld_we = 1'b0;
    logic [6:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic fl_swe, fl_psu, fl_prog, fl_pv, wdt_en, fl_we, fl_re, busy, done, fail;
    logic [6:0] fl_addr;
    logic [7:0] fl_wdata, fl_rdata;
    logic [3:0] attempts;

    int vectors = 0, miscompares = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    flash_pgm_seq #(
        .PAGE_BYTES(P), .EARLY_TRIES(EARLY), .MAX_TRIES(NMAX),
        .T_SWE_ON(TX), .T_SETUP(TY), .T_Z1(TZ1), .T_Z2(TZ2), .T_Z3(TZ3),
        .T_HOLD_A(TA), .T_HOLD_B(TB), .T_PV_ON(TG), .T_SETTLE(TE),
        .T_PV_OFF(TH), .T_EXIT(TT)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .ld_we(ld_we), .ld_addr(ld_addr),
        .ld_data(ld_data), .fl_swe(fl_swe), .fl_psu(fl_psu), .fl_prog(fl_prog),
        .fl_pv(fl_pv), .wdt_en(wdt_en), .fl_we(fl_we), .fl_re(fl_re),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata),
        .busy(busy), .done(done), .fail(fail), .attempts(attempts)
    );

    // stimulus settings shared by array model and reference
    logic [7:0] tgt [P];
    logic [7:0] stuck [P];
    int         req [P];

    // behavioural array driven by the design
    logic [7:0] fm_mem [P];
    logic [7:0] fm_latch [P];
    int         fm_cnt [P];
    logic       prog_d = 1'b0;

    assign fl_rdata = fm_mem[fl_addr];

    always @(posedge clk) begin
        prog_d <= fl_prog;
        if (fl_we && !fl_pv) fm_latch[fl_addr] = fl_wdata;
        if (fl_prog && !prog_d) begin
            for (int a = 0; a < P; a++) begin
                if (fm_latch[a] != 8'hFF) begin
                    fm_cnt[a]++;
                    if (fm_cnt[a] >= req[a]) fm_mem[a] = fm_mem[a] & fm_latch[a];
                end
            end
        end
    end

    // reference model: own array copy and an expected output stream
    logic [7:0] rm_mem [P];
    logic [7:0] rm_latch [P];
    int         rm_cnt [P];
    logic [24:0] exq [$];
    string       tq [$];

    function automatic logic [24:0] mk(bit b, bit s, bit ps, bit pr, bit pv, bit w,
                                       bit we, bit re, int ad, int wd, bit dn, bit fl);
        return {b, s, ps, pr, pv, w, we, re, 7'(ad), 8'(wd), dn, fl};
    endfunction

    task automatic push(input string tg, input int reps, input logic [24:0] v);
        repeat (reps) begin
            exq.push_back(v);
            tq.push_back(tg);
        end
    endtask

    task automatic ref_pulse(input int width, input string tg);
        push(tg, TY, mk(1,1,1,0,0,1,0,0,0,0,0,0));
        for (int a = 0; a < P; a++) begin
            if (rm_latch[a] != 8'hFF) begin
                rm_cnt[a]++;
                if (rm_cnt[a] >= req[a]) rm_mem[a] = rm_mem[a] & rm_latch[a];
            end
        end
        push(tg, width, mk(1,1,1,1,0,1,0,0,0,0,0,0));
        push(tg, TA, mk(1,1,1,0,0,1,0,0,0,0,0,0));
        push(tg, TB, mk(1,1,0,0,0,1,0,0,0,0,0,0));
    endtask

    task automatic ref_run(output int n_out, output bit ok_out);
        logic [7:0] rep [P];
        logic [7:0] add [P];
        logic [7:0] rd;
        int n;
        bit bad;
        push("R1", TX, mk(1,1,0,0,0,0,0,0,0,0,0,0));
        for (int a = 0; a < P; a++) begin rep[a] = tgt[a]; add[a] = 8'hFF; end
        n = 1;
        forever begin
            for (int a = 0; a < P; a++) begin
                push("R4 R12", 1, mk(1,1,0,0,0,0,1,0,a,rep[a],0,0));
                rm_latch[a] = rep[a];
            end
            ref_pulse((n <= EARLY) ? TZ1 : TZ2, "R2 R3");
            push("R5", TG, mk(1,1,0,0,1,0,0,0,0,0,0,0));
            bad = 0;
            for (int a = 0; a < P; a++) begin
                push("R5", 1, mk(1,1,0,0,1,0,1,0,a,8'hFF,0,0));
                push("R5", TE, mk(1,1,0,0,1,0,0,0,0,0,0,0));
                push("R5", 1, mk(1,1,0,0,1,0,0,1,a,0,0,0));
                rd = rm_mem[a];
                if (rd != tgt[a]) bad = 1;
                if (rd == tgt[a] && n <= EARLY) add[a] = tgt[a] | rd;
                rep[a] = tgt[a] | ~rd;
            end
            push("R5", TH, mk(1,1,0,0,0,0,0,0,0,0,0,0));
            if (bad) begin
                if (n >= NMAX) begin ok_out = 0; break; end
                n++;
            end else begin
                if (n <= EARLY) begin
                    for (int a = 0; a < P; a++) begin
                        push("R7", 1, mk(1,1,0,0,0,0,1,0,a,add[a],0,0));
                        rm_latch[a] = add[a];
                    end
                    ref_pulse(TZ3, "R3 R7");
                end
                ok_out = 1;
                break;
            end
        end
        n_out = n;
        push("R9", TT, mk(1,0,0,0,0,0,0,0,0,0,0,0));
        push(ok_out ? ((n <= EARLY) ? "R9 R7" : "R9 R8") : "R9 R6", 1,
             mk(0,0,0,0,0,0,0,0,0,0,ok_out,!ok_out));
        push("R9", 1, mk(0,0,0,0,0,0,0,0,0,0,0,0));
    endtask

    function automatic logic [24:0] dut_vec();
        return {busy, fl_swe, fl_psu, fl_prog, fl_pv, wdt_en, fl_we, fl_re,
                fl_addr, fl_wdata, done, fail};
    endfunction

    task automatic setup(input int mode);
        for (int a = 0; a < P; a++) begin
            tgt[a]   = ((a % 11) == 4) ? 8'hFF : 8'((a * 29 + 7 + mode * 13) & 8'hFF);
            stuck[a] = 8'h00;
            req[a]   = (mode == 2) ? (a % 3) + 1 : 1;
        end
        if (mode == 3) begin
            tgt[17] = 8'h3C; req[17] = 8;
            tgt[90] = 8'h00; req[90] = 7;
        end
        if (mode == 4) begin
            for (int a = 0; a < P; a++) req[a] = 2;
            tgt[5] = 8'hA5; stuck[5] = 8'h01;
        end
        for (int a = 0; a < P; a++) begin
            fm_mem[a] = 8'hFF & ~stuck[a]; rm_mem[a] = fm_mem[a];
            fm_cnt[a] = 0; rm_cnt[a] = 0;
            fm_latch[a] = 8'hFF; rm_latch[a] = 8'hFF;
        end
    endtask

    task automatic load_page();
        for (int a = 0; a < P; a++) begin
            @(negedge clk);
            ld_we = 1'b1; ld_addr = 7'(a); ld_data = tgt[a];
        end
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic run(input string nm, input int inj);
        int nexp;
        bit okexp;
        logic [24:0] ev, av;
        string tg;
        exq.delete(); tq.delete();
        ref_run(nexp, okexp);
        @(negedge clk);
        start = 1'b1;
        for (int i = 0; exq.size() > 0; i++) begin
            @(negedge clk);
            start = (i == inj);
            ev = exq.pop_front();
            tg = tq.pop_front();
            if (inj >= 0 && i > inj) tg = {"R10 ", tg};
            av = dut_vec();
            vectors++;
            if (av !== ev) begin
                miscompares++;
                $display("FAIL %s %s cycle %0d: actual=%h expected=%h", tg, nm, i, av, ev);
            end
        end
        start = 1'b0;
        vectors++;
        if (int'(attempts) !== nexp) begin
            miscompares++;
            $display("FAIL R11 %s attempts: actual=%0d expected=%0d", nm, attempts, nexp);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        vectors++;
        if (dut_vec() !== 25'h0 || attempts !== 4'd0) begin
            miscompares++;
            $display("FAIL R11 reset: actual=%h/%0d expected=0/0", dut_vec(), attempts);
        end
        setup(1); load_page(); run("early-pass", -1);
        setup(2); load_page(); run("graded", -1);
        setup(3); load_page(); run("late-pass", -1);
        setup(4); load_page(); run("exhaust", 300);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL R9 watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule